// File: doc/BRIEF.md
# Serial ADC word-frame aligner

This block sits behind a serial converter lane that has already been sampled once per bit-clock cycle. It rebuilds the serial stream, most significant bit first, into parallel sample words, and it finds the word boundary itself at startup. The boundary is needed because the offset between the first received bit and the true start of a word is unknown after power-up and differs from one power-up to the next.

Two ways of finding the boundary are offered, selected by a static mode input. In training mode the converter is assumed to send a fixed training word. The aligner compares every assembled word with that word. On a mismatch it delays the bit counter by one cycle, which moves the boundary by one bit. In frame mode a frame-clock input, sampled on the same bit clock, marks the first bit of every word with its rising edge, and the deserializer restarts its count there. In both modes a lock flag is raised only after several consecutive words have agreed, and downstream logic uses the sample words once the flag is set.

Top module: `fa_word_aligner`

## Requirements
- R1: While `rst` is high on a clock edge, the bit count, the slip count and the match/run counters are cleared. After that edge `locked`, `align_err` and `word_valid` read 0.
- R2: A word is assembled with the first received bit in bit 7. Once aligned, `word_valid` pulses for one cycle every 8 bit cycles, with `word_out` holding the word whose last bit was sampled on the same edge.
- R3: With `align_mode` = 0 (training), `locked` rises one cycle after the 4th consecutive word equal to 8'hAC. If the stream is aligned from reset, `locked` is still 0 after the 4th word's last bit and is 1 one bit later.
- R4: In training mode, each mismatching word before lock holds the bit count for one cycle, delaying the boundary by one bit. From any starting offset, the aligner locks and then delivers 8'hAC on every `word_valid`.
- R5: After a slip, the next two words are not compared. Slips occur only in training mode while unlocked.
- R6: A mismatch seen after 8 slips without lock raises `align_err` and restarts the slip count. The search goes on, and `align_err` clears when lock is reached. `align_err` and `locked` are never high together.
- R7: Once locked in training mode, no further comparison or slip takes place. Arbitrary data keeps `locked` at 1, and `word_valid` keeps its 8-cycle spacing.
- R8: With `align_mode` = 1 (frame), a rising edge of `frame_clk` marks the bit as the word's first (MSB) bit. After lock, each `word_out` equals the transmitted word.
- R9: In frame mode, `locked` rises only on a frame rising edge, after 4 consecutive rising edges that arrive when the bit count is already at the word start. Two words after the first edge it is still 0.
- R10: In frame mode, a rising edge that arrives at any other bit position clears `locked`, restarts the word count from that edge and restarts the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| align_mode | input | 1 | 0 = training-word search, 1 = frame-clock capture |
| ser_bit | input | 1 | Sampled serial data bit |
| frame_clk | input | 1 | Sampled frame clock, high for the first half of each word |
| word_out | output | WORD_W | Assembled parallel word |
| word_valid | output | 1 | One-cycle strobe when `word_out` is new |
| locked | output | 1 | Word boundary found and confirmed |
| align_err | output | 1 | Training search exhausted its slips without a match |

## Verification
The assertions assume that `align_mode` only changes while `rst` is high. They also assume that in frame mode `frame_clk` rises at most once per word. The word-spacing and slip properties are only meaningful under these assumptions. The stimulus sets the mode inside each reset pulse, holds `frame_clk` high for exactly the first four bits of every word, and drives it low during leading junk bits. It disturbs the frame position only by inserting a single extra data bit, so every edge still belongs to a complete word.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int unsigned DEF_WORD_W = 8;

    typedef enum logic {
        MODE_TRAIN = 1'b0,
        MODE_FRAME = 1'b1
    } align_mode_e;

    typedef enum logic [1:0] {
        TS_HUNT   = 2'd0,
        TS_SETTLE = 2'd1,
        TS_HOLD   = 2'd2
    } train_state_e;

    typedef struct packed {
        logic locked;
        logic err;
    } align_status_t;

    // counter width able to hold the value n-1 (at least one bit)
    function automatic int unsigned cw(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/fa_deser.sv
module fa_deser #(
    parameter int unsigned W = fa_pkg::DEF_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_bit,
    input  logic         slip,
    input  logic         frame_start,
    output logic [W-1:0] word_data,
    output logic         word_valid,
    output logic         phase_zero
);
    localparam int unsigned CW = fa_pkg::cw(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-2:0]  sh_q;
    logic [W-1:0]  word_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] idx;
    logic          done;
    logic          valid_q;

    // a frame start forces the current bit to be the word's first bit
    assign idx  = frame_start ? '0 : cnt_q;
    // a slip cycle neither advances the count nor completes a word
    assign done = !slip && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            sh_q    <= {sh_q[W-3:0], ser_bit};
            valid_q <= done;
            if (done) begin
                word_q <= {sh_q, ser_bit};
            end
            if (slip) begin
                cnt_q <= cnt_q;
            end else if (done) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= idx + 1'b1;
            end
        end
    end

    assign word_data  = word_q;
    assign word_valid = valid_q;
    assign phase_zero = (cnt_q == '0);
endmodule

// File: rtl/fa_frame_edge.sv
module fa_frame_edge (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic frame_in,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= frame_in;
        end
    end

    assign rise = enable && frame_in && !prev_q;
endmodule

// File: rtl/fa_frame_ctl.sv
module fa_frame_ctl #(
    parameter int unsigned LOCK_WORDS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic frame_rise,
    input  logic phase_zero,
    output logic locked
);
    localparam int unsigned RW = fa_pkg::cw(LOCK_WORDS + 1);
    localparam logic [RW-1:0] RUN_MAX  = RW'(LOCK_WORDS);
    localparam logic [RW-1:0] RUN_LAST = RW'(LOCK_WORDS - 1);

    logic [RW-1:0] run_q;
    logic          lock_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (frame_rise) begin
            if (phase_zero) begin
                if (run_q != RUN_MAX) begin
                    run_q <= run_q + 1'b1;
                end
                if (run_q >= RUN_LAST) begin
                    lock_q <= 1'b1;
                end
            end else begin
                run_q  <= '0;
                lock_q <= 1'b0;
            end
        end
    end

    assign locked = lock_q;
endmodule

// File: rtl/fa_train_ctl.sv
module fa_train_ctl #(
    parameter int unsigned   W            = fa_pkg::DEF_WORD_W,
    parameter logic [W-1:0]  PATTERN      = 8'hAC,
    parameter int unsigned   LOCK_WORDS   = 4,
    parameter int unsigned   MAX_SLIPS    = 8,
    parameter int unsigned   SETTLE_WORDS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         word_valid,
    input  logic [W-1:0] word_data,
    output logic         slip,
    output logic         locked,
    output logic         err
);
    import fa_pkg::*;

    localparam int unsigned MW = cw(LOCK_WORDS + 1);
    localparam int unsigned SW = cw(MAX_SLIPS + 1);
    localparam int unsigned KW = cw(SETTLE_WORDS + 1);

    train_state_e  st_q;
    logic [MW-1:0] match_q;
    logic [SW-1:0] slips_q;
    logic [KW-1:0] settle_q;
    logic          slip_q;
    logic          err_q;
    logic          hit;

    assign hit = (word_data == PATTERN);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st_q     <= TS_HUNT;
            match_q  <= '0;
            slips_q  <= '0;
            settle_q <= '0;
            slip_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            slip_q <= 1'b0;
            unique case (st_q)
                TS_HUNT: begin
                    if (word_valid) begin
                        if (hit) begin
                            if (match_q == MW'(LOCK_WORDS - 1)) begin
                                st_q  <= TS_HOLD;
                                err_q <= 1'b0;
                            end
                            match_q <= match_q + 1'b1;
                        end else begin
                            match_q  <= '0;
                            slip_q   <= 1'b1;
                            settle_q <= KW'(SETTLE_WORDS);
                            st_q     <= TS_SETTLE;
                            if (slips_q == SW'(MAX_SLIPS)) begin
                                slips_q <= SW'(1);
                                err_q   <= 1'b1;
                            end else begin
                                slips_q <= slips_q + 1'b1;
                            end
                        end
                    end
                end
                TS_SETTLE: begin
                    if (word_valid) begin
                        settle_q <= settle_q - 1'b1;
                        if (settle_q <= KW'(1)) begin
                            st_q <= TS_HUNT;
                        end
                    end
                end
                TS_HOLD: begin
                    st_q <= TS_HOLD;
                end
                default: st_q <= TS_HUNT;
            endcase
        end
    end

    assign slip   = slip_q;
    assign locked = (st_q == TS_HOLD);
    assign err    = err_q;
endmodule

// File: rtl/fa_word_aligner.sv
module fa_word_aligner #(
    parameter int unsigned        WORD_W       = fa_pkg::DEF_WORD_W,
    parameter logic [WORD_W-1:0]  TRAIN_WORD   = 8'hAC,
    parameter int unsigned        LOCK_WORDS   = 4,
    parameter int unsigned        MAX_SLIPS    = 8,
    parameter int unsigned        SETTLE_WORDS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              align_mode,
    input  logic              ser_bit,
    input  logic              frame_clk,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              locked,
    output logic              align_err
);
    import fa_pkg::*;

    logic          train_en;
    logic          frame_en;
    logic          t_slip;
    logic          t_locked;
    logic          t_err;
    logic          f_rise;
    logic          f_locked;
    logic          phase_zero;
    align_status_t status;

    assign train_en = (align_mode == MODE_TRAIN);
    assign frame_en = (align_mode == MODE_FRAME);

    fa_deser #(.W(WORD_W)) u_deser (
        .clk         (clk),
        .rst         (rst),
        .ser_bit     (ser_bit),
        .slip        (t_slip),
        .frame_start (f_rise),
        .word_data   (word_out),
        .word_valid  (word_valid),
        .phase_zero  (phase_zero)
    );

    fa_frame_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .enable   (frame_en),
        .frame_in (frame_clk),
        .rise     (f_rise)
    );

    fa_train_ctl #(
        .W            (WORD_W),
        .PATTERN      (TRAIN_WORD),
        .LOCK_WORDS   (LOCK_WORDS),
        .MAX_SLIPS    (MAX_SLIPS),
        .SETTLE_WORDS (SETTLE_WORDS)
    ) u_train (
        .clk        (clk),
        .rst        (rst),
        .enable     (train_en),
        .word_valid (word_valid),
        .word_data  (word_out),
        .slip       (t_slip),
        .locked     (t_locked),
        .err        (t_err)
    );

    fa_frame_ctl #(.LOCK_WORDS(LOCK_WORDS)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .enable     (frame_en),
        .frame_rise (f_rise),
        .phase_zero (phase_zero),
        .locked     (f_locked)
    );

    always_comb begin
        if (train_en) begin
            status.locked = t_locked;
            status.err    = t_err;
        end else begin
            status.locked = f_locked;
            status.err    = 1'b0;
        end
    end

    assign locked    = status.locked;
    assign align_err = status.err;
endmodule

// File: rtl/fa_word_aligner_chk.sv
module fa_word_aligner_chk #(
    parameter int unsigned W = fa_pkg::DEF_WORD_W
) (
    input logic clk,
    input logic rst,
    input logic align_mode,
    input logic word_valid,
    input logic locked,
    input logic align_err,
    input logic slip,
    input logic frame_rise,
    input logic phase_zero
);
    localparam int unsigned GW = fa_pkg::cw(W + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(W);

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (word_valid) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!locked && !align_err && !word_valid));

    a_r2_word_spacing: assert property (@(posedge clk) disable iff (rst)
        (!align_mode && word_valid && seen_q) |-> (gap_q >= GW'(W - 1)));

    a_r3_lock_on_word: assert property (@(posedge clk) disable iff (rst)
        (!align_mode && $rose(locked)) |-> $past(word_valid));

    a_r5_slip_only_hunting: assert property (@(posedge clk) disable iff (rst)
        slip |-> (!align_mode && !locked));

    a_r6_err_excludes_lock: assert property (@(posedge clk) disable iff (rst)
        align_err |-> !locked);

    a_r9_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
        (align_mode && $rose(locked)) |-> $past(frame_rise));

    a_r10_misplaced_edge: assert property (@(posedge clk) disable iff (rst)
        (align_mode && frame_rise && !phase_zero) |=> !locked);
endmodule

bind fa_word_aligner fa_word_aligner_chk #(.W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .align_mode (align_mode),
    .word_valid (word_valid),
    .locked     (locked),
    .align_err  (align_err),
    .slip       (t_slip),
    .frame_rise (f_rise),
    .phase_zero (phase_zero)
);

// File: tb/fa_word_aligner_bench.sv
module fa_word_aligner_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] TRAIN = 8'hAC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       align_mode = 1'b0;
    logic       ser_bit = 1'b0;
    logic       frame_clk = 1'b0;
    logic [7:0] word_out;
    logic       word_valid;
    logic       locked;
    logic       align_err;

    int   n_vec = 0;
    int   n_fail = 0;
    bit   chk_data = 0;
    bit   chk_gap = 0;
    bit   gap_seen = 0;
    int   gap = 0;
    logic [7:0] exp_word = 8'h00;
    string data_req = "R4";

    always #(CLK_PERIOD / 2) clk = ~clk;

    fa_word_aligner u_fa_word_aligner (
        .clk        (clk),
        .rst        (rst),
        .align_mode (align_mode),
        .ser_bit    (ser_bit),
        .frame_clk  (frame_clk),
        .word_out   (word_out),
        .word_valid (word_valid),
        .locked     (locked),
        .align_err  (align_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one bit at a falling edge, then look at the outputs one edge later
    task automatic step(input logic b, input logic f);
        ser_bit   = b;
        frame_clk = f;
        @(negedge clk);
        gap++;
        if (word_valid) begin
            if (chk_data && locked) check(word_out == exp_word, data_req, word_out, exp_word);
            if (chk_gap && gap_seen) check(gap == 8, "R2 spacing", gap, 8);
            gap_seen = 1;
            gap = 0;
        end
    endtask

    task automatic send_word(input logic [7:0] w, input bit fr);
        exp_word = (align_mode == 1'b0) ? TRAIN : w;
        for (int i = 0; i < 8; i++) step(w[7-i], fr && (i < 4));
    endtask

    task automatic junk_bits(input int k);
        for (int i = 0; i < k; i++) step(1'($urandom_range(1, 0)), 1'b0);
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1;
        align_mode = mode;
        ser_bit = 1'b0;
        frame_clk = 1'b0;
        chk_data = 0;
        chk_gap = 0;
        gap_seen = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic train_trial(input int k);
        do_reset(1'b0);
        data_req = "R4";
        junk_bits(k);
        for (int i = 0; i < 60 && !locked; i++) send_word(TRAIN, 1'b0);
        check(locked == 1'b1, "R4 R5 lock from offset", locked, 1);
        check(align_err == 1'b0, "R6 no error with pattern", align_err, 0);
        chk_data = 1; chk_gap = 1; gap_seen = 0;
        for (int i = 0; i < 6; i++) send_word(TRAIN, 1'b0);
        chk_data = 0;
        for (int i = 0; i < 5; i++) send_word(8'($urandom), 1'b0);
        check(locked == 1'b1, "R7 lock held on data", locked, 1);
        check(align_err == 1'b0, "R7 no error on data", align_err, 0);
        chk_gap = 0;
    endtask

    initial begin
        void'($urandom(32'd4711));

        // R1: reset state
        do_reset(1'b0);
        check(locked == 1'b0, "R1 locked after reset", locked, 0);
        check(align_err == 1'b0, "R1 err after reset", align_err, 0);
        check(word_valid == 1'b0, "R1 valid after reset", word_valid, 0);

        // R3: aligned from reset, exact lock point
        for (int i = 0; i < 4; i++) send_word(TRAIN, 1'b0);
        check(locked == 1'b0, "R3 not locked at 4th word end", locked, 0);
        step(TRAIN[7], 1'b0);
        check(locked == 1'b1, "R3 locked one bit later", locked, 1);

        // R4, R5, R7: various starting offsets
        train_trial(3);
        train_trial(7);
        for (int t = 0; t < 3; t++) train_trial(int'($urandom_range(15, 1)));

        // R6: no pattern -> error, then recovery
        do_reset(1'b0);
        for (int i = 0; i < 40; i++) send_word(8'h00, 1'b0);
        check(align_err == 1'b1, "R6 error raised", align_err, 1);
        check(locked == 1'b0, "R6 not locked without pattern", locked, 0);
        junk_bits(5);
        for (int i = 0; i < 80 && !locked; i++) send_word(TRAIN, 1'b0);
        check(locked == 1'b1, "R6 lock after restart", locked, 1);
        check(align_err == 1'b0, "R6 error cleared on lock", align_err, 0);

        // R8, R9, R10: frame-clock mode
        for (int t = 0; t < 3; t++) begin
            do_reset(1'b1);
            data_req = "R8";
            chk_data = 1;
            junk_bits(int'($urandom_range(13, 0)));
            for (int i = 0; i < 2; i++) send_word(8'($urandom), 1'b1);
            check(locked == 1'b0, "R9 not locked after two edges", locked, 0);
            for (int i = 0; i < 6; i++) send_word(8'($urandom), 1'b1);
            check(locked == 1'b1, "R9 locked after run", locked, 1);
            chk_gap = 1; gap_seen = 0;
            send_word(8'h80, 1'b1);
            send_word(8'h01, 1'b1);
            for (int i = 0; i < 8; i++) send_word(8'($urandom), 1'b1);
            chk_gap = 0;
            step(1'b1, 1'b0);
            send_word(8'($urandom), 1'b1);
            check(locked == 1'b0, "R10 lock dropped", locked, 0);
            for (int i = 0; i < 5; i++) send_word(8'($urandom), 1'b1);
            check(locked == 1'b1, "R10 relocked", locked, 1);
            for (int i = 0; i < 4; i++) send_word(8'($urandom), 1'b1);
        end

        // R1: reset while locked
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(locked == 1'b0, "R1 locked cleared by reset", locked, 0);
        check(word_valid == 1'b0, "R1 valid cleared by reset", word_valid, 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule